// File: doc/BRIEF.md
# Chained descriptor DMA channel

A single DMA channel that copies a block of bytes between a local memory port and a bus-master port, in either direction. Software can start it in two ways. It can set the channel's descriptor pointer to a linked list of 16-byte descriptors in local memory and let the channel fetch them one by one. Or it can write one descriptor's values straight into the channel registers and start from those. The source and the destination may each start at any byte offset. A small merge buffer realigns the bytes between the two offsets.

Software reaches the channel through a simple register port. The select codes are 0 control, 1 byte count, 2 bus address (low 32 bits), 3 local address, 4 descriptor pointer and 5 bus address (high 32 bits). Both memory ports use a request/acknowledge handshake. Each access is one 32-bit word at a word-aligned address, with byte enables.

Control register fields:

| Bit | Field |
|-----|-------|
| 0 | enable |
| 2 | transfer done |
| 3 | direction: 1 means local to bus, 0 means bus to local |
| 4 | start from the register values |
| 6:5 | bus read type |
| 7 | chain done |

A descriptor is four little-endian words:

| Word | Contents |
|------|----------|
| 0 | byte count in bits [CW-1:0], end-of-chain flag in bit 31 |
| 1 | bus address, low 32 bits |
| 2 | local address in bits [30:0], wide flag in bit 31 |
| 3 | next-descriptor pointer; when the wide flag is set, the upper 32 bits of the bus address instead |

Top module: `desc_dma_chan`

## Requirements
- R1: After reset, the control, count, address and pointer registers all read 0 and neither port raises a request.
- R2: Setting enable (bit 0) with bit 4 set starts the copy at once from the register values. No descriptor is read.
- R3: Setting enable with bit 4 clear first reads the four words at the descriptor pointer, in the layout given above, and then copies. A pointer word (word 3, wide flag clear) is loaded into the pointer register.
- R4: When a descriptor's count has been consumed, the channel sets transfer done (bit 2). If end of chain is clear, it fetches the next descriptor. If end of chain is set, it sets chain done (bit 7), clears enable and stops.
- R5: A descriptor with the wide flag set supplies bits [63:32] of the bus address in word 3. The next descriptor is then taken from that descriptor's address plus 16. A descriptor whose wide flag is clear drives the upper bus address bits as 0.
- R6: Bus reads use command code 00 when control [6:5] is 00, code 01 when it is 01, and code 10 when it is 10 or 11. Bus writes use code 11.
- R7: Every read enables all four byte lanes. After each read, the count register drops by the number of useful bytes read and the source address rises by the same amount. Each source word is read once.
- R8: The first write enables only the lanes from the destination's low two address bits upward. Later writes start at lane 0. The last write enables only the lanes that the remaining count covers.
- R9: The destination receives exactly the count bytes of the source, in order, for any pair of source and destination byte offsets. Bytes outside that range are unchanged.
- R10: A descriptor with a count of 0 finishes, with its done bits set, without any data access.
- R11: Clearing enable during a copy stops the channel at the next word boundary. It sets no done bit, makes no further request, and leaves a partly consumed count in the count register.
- R12: Only one port requests at a time. Every request address is word aligned. A request holds its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 ctrl, 1 count, 2 bus low, 3 local, 4 pointer, 5 bus high) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| lm_req | output | 1 | Local memory request |
| lm_we | output | 1 | Local memory write (1) or read (0) |
| lm_addr | output | 32 | Local memory word-aligned byte address |
| lm_wdata | output | 32 | Local memory write data |
| lm_be | output | 4 | Local memory byte enables |
| lm_rdata | input | 32 | Local memory read data, valid with lm_ack |
| lm_ack | input | 1 | Local memory acknowledge |
| bm_req | output | 1 | Bus request |
| bm_we | output | 1 | Bus write (1) or read (0) |
| bm_cmd | output | 2 | Bus command code (see R6) |
| bm_addr | output | 64 | Bus word-aligned byte address |
| bm_wdata | output | 32 | Bus write data |
| bm_be | output | 4 | Bus byte enables |
| bm_rdata | input | 32 | Bus read data, valid with bm_ack |
| bm_ack | input | 1 | Bus acknowledge |

## Verification
The properties assume that each port acknowledges only while its request is high, and for one cycle per access. They also assume that software writes registers other than control only while the channel is idle, and that descriptor pointers are word aligned. The bench's two memory models answer every request with a single acknowledge one cycle after it appears, and then drop it. The scenarios write the address, count and pointer registers only before setting enable. All descriptors are placed at word-aligned addresses.

// File: rtl/desc_dma_chan.sv
module desc_dma_chan #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        lm_req,
  output logic        lm_we,
  output logic [31:0] lm_addr,
  output logic [31:0] lm_wdata,
  output logic [3:0]  lm_be,
  input  logic [31:0] lm_rdata,
  input  logic        lm_ack,
  output logic        bm_req,
  output logic        bm_we,
  output logic [1:0]  bm_cmd,
  output logic [63:0] bm_addr,
  output logic [31:0] bm_wdata,
  output logic [3:0]  bm_be,
  input  logic [31:0] bm_rdata,
  input  logic        bm_ack
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SETUP, S_MOVE, S_RD, S_WR, S_DONE} st_t;

  st_t st;
  logic en, dir, usereg, xdone, cdone, eoc;
  logic [1:0] rtype, fidx, sidx, didx;
  logic [CW-1:0] rcnt, wcnt;
  logic [31:0] bad, bhi, lad, dp, wd;
  logic [63:0] mbuf, mbuf_rd;
  logic [3:0] nb, wbe;
  logic [2:0] room_r, room_w, n_rd, n_wr;

  wire busy = (st != S_IDLE);
  wire [1:0] soff = dir ? lad[1:0] : bad[1:0];
  wire [1:0] doff = dir ? bad[1:0] : lad[1:0];
  wire [31:0] rd_word = dir ? lm_rdata : bm_rdata;
  wire rd_ack = dir ? lm_ack : bm_ack;
  wire wr_ack = dir ? bm_ack : lm_ack;
  wire wr_ok = ({1'b0, n_wr} <= nb);
  wire [1:0] rcmd = (rtype == 2'b11) ? 2'b10 : rtype;
  wire [31:0] faddr = {dp[31:2], 2'b00} + {28'd0, fidx, 2'b00};
  wire [31:0] la_w = {1'b0, lad[30:2], 2'b00};
  wire [63:0] ba_w = {bhi, bad[31:2], 2'b00};

  assign room_r = 3'd4 - {1'b0, soff};
  assign room_w = 3'd4 - {1'b0, doff};
  assign n_rd = (rcnt < CW'(room_r)) ? rcnt[2:0] : room_r;
  assign n_wr = (wcnt < CW'(room_w)) ? wcnt[2:0] : room_w;

  always_comb begin
    mbuf_rd = mbuf;
    sidx = '0;
    for (int k = 0; k < 8; k++) begin
      if (4'(k) >= nb && (4'(k) - nb) < {1'b0, n_rd}) begin
        sidx = soff + 2'(4'(k) - nb);
        mbuf_rd[8*k +: 8] = rd_word[8*sidx +: 8];
      end
    end
  end

  always_comb begin
    wbe = '0;
    wd = '0;
    didx = '0;
    for (int j = 0; j < 4; j++) begin
      if (2'(j) >= doff && (3'(j) - {1'b0, doff}) < n_wr) begin
        didx = 2'(j) - doff;
        wbe[j] = 1'b1;
        wd[8*j +: 8] = mbuf[8*didx +: 8];
      end
    end
  end

  always_comb begin
    lm_req = 1'b0; lm_we = 1'b0; lm_addr = '0; lm_wdata = '0; lm_be = '0;
    bm_req = 1'b0; bm_we = 1'b0; bm_cmd = '0; bm_addr = '0; bm_wdata = '0; bm_be = '0;
    case (st)
      S_FETCH: begin
        lm_req = 1'b1; lm_addr = faddr; lm_be = 4'hf;
      end
      S_RD: begin
        if (dir) begin
          lm_req = 1'b1; lm_addr = la_w; lm_be = 4'hf;
        end else begin
          bm_req = 1'b1; bm_addr = ba_w; bm_be = 4'hf; bm_cmd = rcmd;
        end
      end
      S_WR: begin
        if (dir) begin
          bm_req = 1'b1; bm_we = 1'b1; bm_cmd = 2'b11; bm_addr = ba_w;
          bm_be = wbe; bm_wdata = wd;
        end else begin
          lm_req = 1'b1; lm_we = 1'b1; lm_addr = la_w; lm_be = wbe; lm_wdata = wd;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_sel)
      3'd0: reg_rdata = {24'd0, cdone, rtype, usereg, dir, xdone, 1'b0, en};
      3'd1: reg_rdata = {eoc, {(31-CW){1'b0}}, rcnt};
      3'd2: reg_rdata = bad;
      3'd3: reg_rdata = lad;
      3'd4: reg_rdata = dp;
      3'd5: reg_rdata = bhi;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      en <= 1'b0; dir <= 1'b0; usereg <= 1'b0; xdone <= 1'b0; cdone <= 1'b0;
      eoc <= 1'b0; rtype <= '0; fidx <= '0;
      rcnt <= '0; wcnt <= '0;
      bad <= '0; bhi <= '0; lad <= '0; dp <= '0;
      mbuf <= '0; nb <= '0;
    end else begin
      if (reg_we) begin
        if (reg_sel == 3'd0) begin
          en <= reg_wdata[0];
          if (!busy) begin
            xdone <= 1'b0;
            cdone <= 1'b0;
            dir <= reg_wdata[3];
            usereg <= reg_wdata[4];
            rtype <= reg_wdata[6:5];
          end
        end else if (!busy) begin
          case (reg_sel)
            3'd1: begin eoc <= reg_wdata[31]; rcnt <= reg_wdata[CW-1:0]; end
            3'd2: bad <= reg_wdata;
            3'd3: lad <= reg_wdata;
            3'd4: dp <= reg_wdata;
            3'd5: bhi <= reg_wdata;
            default: ;
          endcase
        end
      end

      case (st)
        S_IDLE: begin
          fidx <= '0;
          if (en) st <= usereg ? S_SETUP : S_FETCH;
        end
        S_FETCH: if (lm_ack) begin
          fidx <= fidx + 2'd1;
          case (fidx)
            2'd0: begin eoc <= lm_rdata[31]; rcnt <= lm_rdata[CW-1:0]; end
            2'd1: bad <= lm_rdata;
            2'd2: lad <= lm_rdata;
            default: begin
              if (lad[31]) begin
                bhi <= lm_rdata;
                dp <= {dp[31:2], 2'b00} + 32'd16;
              end else begin
                bhi <= '0;
                dp <= lm_rdata;
              end
              st <= S_SETUP;
            end
          endcase
        end
        S_SETUP: begin
          wcnt <= rcnt;
          nb <= '0;
          mbuf <= '0;
          st <= (rcnt == '0) ? S_DONE : S_MOVE;
        end
        S_MOVE: begin
          if (wcnt == '0) st <= S_DONE;
          else if (!en) st <= S_IDLE;
          else if (wr_ok) st <= S_WR;
          else st <= S_RD;
        end
        S_RD: if (rd_ack) begin
          mbuf <= mbuf_rd;
          nb <= nb + {1'b0, n_rd};
          rcnt <= rcnt - CW'(n_rd);
          if (dir) lad[30:0] <= lad[30:0] + 31'(n_rd);
          else {bhi, bad} <= {bhi, bad} + 64'(n_rd);
          st <= S_MOVE;
        end
        S_WR: if (wr_ack) begin
          mbuf <= mbuf >> {n_wr, 3'b000};
          nb <= nb - {1'b0, n_wr};
          wcnt <= wcnt - CW'(n_wr);
          if (dir) {bhi, bad} <= {bhi, bad} + 64'(n_wr);
          else lad[30:0] <= lad[30:0] + 31'(n_wr);
          st <= S_MOVE;
        end
        S_DONE: begin
          xdone <= 1'b1;
          fidx <= '0;
          if (eoc) begin
            cdone <= 1'b1;
            en <= 1'b0;
            st <= S_IDLE;
          end else if (!en) begin
            st <= S_IDLE;
          end else begin
            st <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/desc_dma_chan_chk.sv
module desc_dma_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lm_req,
  input logic        lm_we,
  input logic [31:0] lm_addr,
  input logic [3:0]  lm_be,
  input logic        lm_ack,
  input logic        bm_req,
  input logic        bm_we,
  input logic [1:0]  bm_cmd,
  input logic [63:0] bm_addr,
  input logic [3:0]  bm_be,
  input logic        bm_ack,
  input logic        en,
  input logic        xdone,
  input logic        cdone
);

  // R12
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n) !(lm_req && bm_req));

  // R12
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lm_req |-> lm_addr[1:0] == 2'b00) and (bm_req |-> bm_addr[1:0] == 2'b00));

  // R12
  lm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lm_req && !lm_ack |=> lm_req && $stable(lm_addr) && $stable(lm_we));

  // R12
  bm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req && !bm_ack |=> bm_req && $stable(bm_addr) && $stable(bm_we));

  // R7
  rd_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lm_req && !lm_we) |-> lm_be == 4'hf) and ((bm_req && !bm_we) |-> bm_be == 4'hf));

  // R8
  wr_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lm_req && lm_we) |-> lm_be != 4'h0) and ((bm_req && bm_we) |-> bm_be != 4'h0));

  // R6
  wr_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && bm_we) |-> bm_cmd == 2'b11);

  // R4
  chain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cdone) |-> xdone && !en);

endmodule

bind desc_dma_chan desc_dma_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .lm_req(lm_req), .lm_we(lm_we), .lm_addr(lm_addr), .lm_be(lm_be), .lm_ack(lm_ack),
  .bm_req(bm_req), .bm_we(bm_we), .bm_cmd(bm_cmd), .bm_addr(bm_addr), .bm_be(bm_be),
  .bm_ack(bm_ack), .en(en), .xdone(xdone), .cdone(cdone)
);

// File: tb/desc_dma_chan_test.sv
`timescale 1ns/1ps
module desc_dma_chan_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic lm_req, lm_we, bm_req, bm_we;
  logic [31:0] lm_addr, lm_wdata, bm_wdata;
  logic [3:0] lm_be, bm_be;
  logic [1:0] bm_cmd;
  logic [63:0] bm_addr;
  logic [31:0] lm_rdata = '0, bm_rdata = '0;
  logic lm_ack = 1'b0, bm_ack = 1'b0;

  int total = 0, bad = 0;
  logic [7:0] lmem [0:1023];
  logic [7:0] bmem [0:1023];
  int n_lrd = 0, n_lwr = 0, n_brd = 0, n_bwr = 0;
  logic [3:0] first_be = '0, last_be = '0;
  logic [31:0] first_hi = '0;
  logic [1:0] last_cmd = '0;
  logic arm_first = 1'b0;

  always #2 clk = ~clk;

  desc_dma_chan uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lm_req(lm_req), .lm_we(lm_we), .lm_addr(lm_addr),
    .lm_wdata(lm_wdata), .lm_be(lm_be), .lm_rdata(lm_rdata), .lm_ack(lm_ack),
    .bm_req(bm_req), .bm_we(bm_we), .bm_cmd(bm_cmd), .bm_addr(bm_addr),
    .bm_wdata(bm_wdata), .bm_be(bm_be), .bm_rdata(bm_rdata), .bm_ack(bm_ack)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      lm_ack <= 1'b0;
    end else if (lm_req && !lm_ack) begin
      lm_ack <= 1'b1;
      lm_rdata <= {lmem[lm_addr[9:0]+3], lmem[lm_addr[9:0]+2], lmem[lm_addr[9:0]+1], lmem[lm_addr[9:0]]};
      if (lm_we) begin
        for (int i = 0; i < 4; i++) if (lm_be[i]) lmem[lm_addr[9:0]+i] = lm_wdata[8*i +: 8];
        n_lwr <= n_lwr + 1;
        last_be <= lm_be;
        if (arm_first) begin first_be <= lm_be; arm_first <= 1'b0; end
      end else n_lrd <= n_lrd + 1;
    end else lm_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      bm_ack <= 1'b0;
    end else if (bm_req && !bm_ack) begin
      bm_ack <= 1'b1;
      bm_rdata <= {bmem[bm_addr[9:0]+3], bmem[bm_addr[9:0]+2], bmem[bm_addr[9:0]+1], bmem[bm_addr[9:0]]};
      if (bm_we) begin
        for (int i = 0; i < 4; i++) if (bm_be[i]) bmem[bm_addr[9:0]+i] = bm_wdata[8*i +: 8];
        n_bwr <= n_bwr + 1;
        last_be <= bm_be;
        if (arm_first) begin first_be <= bm_be; first_hi <= bm_addr[63:32]; arm_first <= 1'b0; end
      end else begin
        n_brd <= n_brd + 1;
        last_cmd <= bm_cmd;
      end
    end else bm_ack <= 1'b0;
  end

  function automatic logic [7:0] lpat(int i); return 8'(i * 5 + 1); endfunction
  function automatic logic [7:0] bpat(int i); return 8'(i * 3 + 8'h40); endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 1024; i++) begin lmem[i] = lpat(i); bmem[i] = bpat(i); end
  endtask

  task automatic put_word(int a, logic [31:0] w);
    for (int i = 0; i < 4; i++) lmem[a+i] = w[8*i +: 8];
  endtask

  task automatic wr_reg(logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic wait_stop();
    logic [31:0] c;
    for (int n = 0; n < 5000; n++) begin
      rd_reg(3'd0, c);
      if (!c[0]) break;
    end
  endtask

  task automatic check_copy(string req, bit to_bus, int src, int dst, int cnt);
    int errs = 0;
    logic [7:0] e, a;
    for (int i = dst - 4; i < dst + cnt + 4; i++) begin
      if (i >= dst && i < dst + cnt) e = to_bus ? lpat(src + i - dst) : bpat(src + i - dst);
      else e = to_bus ? bpat(i) : lpat(i);
      a = to_bus ? bmem[i] : lmem[i];
      if (a !== e) errs++;
    end
    check(req, 64'(errs), 64'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(3'd0, d); check("R1 ctrl after reset", d, 0);
    rd_reg(3'd1, d); check("R1 count after reset", d, 0);
    rd_reg(3'd4, d); check("R1 pointer after reset", d, 0);
    check("R1 no request after reset", {lm_req, bm_req}, 0);
  endtask

  task automatic t_regmode();
    logic [31:0] d;
    int r0;
    fill();
    r0 = n_lrd;
    wr_reg(3'd1, 32'h8000_0008);
    wr_reg(3'd2, 32'h100);
    wr_reg(3'd3, 32'h040);
    wr_reg(3'd5, 32'h0);
    wr_reg(3'd0, 32'h19);
    wait_stop();
    check_copy("R9 aligned local to bus", 1, 'h40, 'h100, 8);
    check("R2 no descriptor read", 64'(n_lrd - r0), 2);
    rd_reg(3'd0, d); check("R4 ctrl after single", d, 32'h9C);
    rd_reg(3'd1, d); check("R7 count consumed", d, 32'h8000_0000);
    rd_reg(3'd3, d); check("R7 source advanced", d, 32'h48);
    rd_reg(3'd2, d); check("R7 destination advanced", d, 32'h108);
  endtask

  task automatic t_unaligned();
    logic [31:0] d;
    int r0;
    fill();
    r0 = n_lrd;
    wr_reg(3'd1, 32'h8000_000B);
    wr_reg(3'd2, 32'h203);
    wr_reg(3'd3, 32'h061);
    wr_reg(3'd5, 32'h0);
    arm_first = 1'b1;
    wr_reg(3'd0, 32'h19);
    wait_stop();
    check_copy("R9 offsets 1 to 3", 1, 'h61, 'h203, 11);
    check("R8 first write lanes", first_be, 4'b1000);
    check("R8 last write lanes", last_be, 4'b0011);
    check("R7 one read per source word", 64'(n_lrd - r0), 3);
    rd_reg(3'd2, d); check("R7 bus address end", d, 32'h20E);
    rd_reg(3'd3, d); check("R7 local address end", d, 32'h06C);
  endtask

  task automatic t_readtype();
    logic [31:0] d;
    int b, l;
    for (int rt = 0; rt < 4; rt++) begin
      fill();
      b = 'h300 + rt;
      l = 'h183 + 'h1F * rt;
      wr_reg(3'd1, 32'h8000_0000 | 32'(6 + rt));
      wr_reg(3'd2, 32'(b));
      wr_reg(3'd3, 32'(l));
      wr_reg(3'd5, 32'h0);
      wr_reg(3'd0, 32'h11 | 32'(rt << 5));
      wait_stop();
      check_copy("R9 bus to local", 0, b, l, 6 + rt);
      check("R6 read command", last_cmd, (rt == 3) ? 2'b10 : 2'(rt));
      rd_reg(3'd0, d); check("R4 ctrl after bus read", d, 32'h94 | 32'(rt << 5));
    end
  endtask

  task automatic t_chain();
    logic [31:0] d;
    int r0;
    fill();
    put_word('h380, 32'h0000_0005); put_word('h384, 32'h040);
    put_word('h388, 32'h011);       put_word('h38C, 32'h3A0);
    put_word('h3A0, 32'h8000_0007); put_word('h3A4, 32'h083);
    put_word('h3A8, 32'h022);       put_word('h3AC, 32'hDEAD_BEE0);
    r0 = n_lrd;
    wr_reg(3'd4, 32'h380);
    wr_reg(3'd0, 32'h09);
    wait_stop();
    check_copy("R3 first descriptor data", 1, 'h11, 'h40, 5);
    check_copy("R4 second descriptor data", 1, 'h22, 'h83, 7);
    check("R3 descriptor and data reads", 64'(n_lrd - r0), 13);
    rd_reg(3'd4, d); check("R3 pointer loaded", d, 32'hDEAD_BEE0);
    rd_reg(3'd0, d); check("R4 ctrl after chain", d, 32'h8C);
  endtask

  task automatic t_wide();
    logic [31:0] d;
    fill();
    put_word('h3C0, 32'h0000_0004); put_word('h3C4, 32'h0C0);
    put_word('h3C8, 32'h8000_0050); put_word('h3CC, 32'h0000_0007);
    put_word('h3D0, 32'h8000_0004); put_word('h3D4, 32'h0D1);
    put_word('h3D8, 32'h060);       put_word('h3DC, 32'h0);
    wr_reg(3'd4, 32'h3C0);
    arm_first = 1'b1;
    wr_reg(3'd0, 32'h09);
    wait_stop();
    check("R5 upper bus address", first_hi, 32'h7);
    check_copy("R5 wide descriptor data", 1, 'h50, 'hC0, 4);
    check_copy("R5 next at plus 16", 1, 'h60, 'hD1, 4);
    rd_reg(3'd5, d); check("R5 upper cleared by narrow", d, 0);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    int s0;
    fill();
    s0 = n_lrd + n_lwr + n_brd + n_bwr;
    wr_reg(3'd1, 32'h8000_0000);
    wr_reg(3'd0, 32'h19);
    wait_stop();
    check("R10 no data access", 64'(n_lrd + n_lwr + n_brd + n_bwr - s0), 0);
    rd_reg(3'd0, d); check("R10 done bits set", d, 32'h9C);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    int s0;
    fill();
    wr_reg(3'd1, 32'h8000_00C8);
    wr_reg(3'd2, 32'h200);
    wr_reg(3'd3, 32'h000);
    wr_reg(3'd5, 32'h0);
    wr_reg(3'd0, 32'h19);
    repeat (40) @(negedge clk);
    wr_reg(3'd0, 32'h18);
    repeat (10) @(negedge clk);
    s0 = n_lrd + n_lwr + n_brd + n_bwr;
    repeat (30) @(negedge clk);
    check("R11 no request after abort", 64'(n_lrd + n_lwr + n_brd + n_bwr - s0), 0);
    rd_reg(3'd0, d); check("R11 no done bits", d, 32'h18);
    rd_reg(3'd1, d);
    check("R11 partial count", (d[15:0] > 0 && d[15:0] < 200), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmode();
    t_unaligned();
    t_readtype();
    t_chain();
    t_wide();
    t_zero();
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule